// File: doc/BRIEF.md
# Hierarchical Carry Lookahead Adder

This block adds two 64-bit operands and a carry-in and returns a 64-bit sum and a carry-out. It has no clock and no reset. The result settles from the inputs through combinational logic alone. It is meant as the adder core of a datapath, where a long ripple chain would set the critical path.

The carries are not rippled from bit to bit. Each bit first forms a generate signal (both operand bits set) and a propagate signal (either operand bit set, an inclusive OR). A four-input lookahead unit turns four such pairs into a group generate and a group propagate. The same unit is applied again to four groups at once, which gives terms that cover 16 bits. A final unit works over the four 16-bit blocks and the carry-in.

Carries then flow back down the tree:
- the top unit gives the carry into each 16-bit block;
- the second-level units give the carry into each 4-bit group;
- the first-level units give the carry into each bit.

Every AND or OR term in the lookahead logic has at most four inputs. Each sum bit is the XOR of the two operand bits and the carry into that bit.

Top module: `hcla_adder64`

## Requirements
- R1: For any operands and carry-in, the concatenation {co, s} equals the 65-bit value a + b + ci.
- R2: With both operands zero, s equals ci zero-extended and co is 0.
- R3: With a all ones, b zero and ci = 1, the carry propagates through every group and every 16-bit block, giving s = 0 and co = 1. The carry into each 16-bit block equals the previous block's generate OR (its propagate AND its carry-in).
- R4: A carry generated inside group k (bits 4k to 4k+3) arrives at bit 4k+4, for every k from 0 to 15. For k = 15 it arrives at co. Each group carry equals the previous group's generate OR (its propagate AND its carry-in).
- R5: Bits where both operands are 1, so that generate and propagate are both asserted, give the correct result. In particular a = b = all ones with ci = 1 gives s = all ones and co = 1.
- R6: The alternating operands 0x5555...5 and 0xAAAA...A sum to all ones with co = 0 when ci = 0, and to zero with co = 1 when ci = 1.
- R7: Setting bit i in both operands, with ci = 0, yields s with only bit i+1 set for i < 63, and co = 1 with s = 0 for i = 63. The carry into each bit equals the previous bit's generate OR (its propagate AND its carry).
- R8: The outputs follow an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| ci | input | 1 | Carry into bit 0 |
| s | output | 64 | Sum |
| co | output | 1 | Carry out of bit 63 |

## Verification
The bench builds the adder at its default width of 64 bits. At that width the tree is fully populated: sixteen 4-bit groups, four 16-bit blocks and one top unit. A carry can therefore be made to cross each of the sixteen group boundaries and each of the four block boundaries, and to leave through the carry-out. Directed single-bit, group-generate and full-propagate operands drive every level of the tree. Random operands with both carry-in values cover mixed generate and propagate patterns.

// File: rtl/hcla_pkg.sv
// Package: shared sizing for the hierarchical lookahead adder.
// Assumes a fixed lookahead fan-in of four at every tree level.
package hcla_pkg;
    localparam int unsigned LA_FANIN = 4;
endpackage

// File: rtl/hcla_la4.sv
// Module: four-way lookahead unit.
// Takes four generate/propagate pairs and a carry-in. Returns the carries
// into positions 1..3 and the combined generate/propagate of the four.
// The same unit serves bits, groups and blocks. No term exceeds four inputs.
module hcla_la4 (
    input  logic [3:0] pi,
    input  logic [3:0] gi,
    input  logic       cin,
    output logic [3:1] cout,
    output logic       gg,
    output logic       gp
);
    // Purpose: flat sum-of-products carries and group terms, no internal ripple.
    always_comb begin
        cout[1] = gi[0] | (pi[0] & cin);
        cout[2] = gi[1] | (pi[1] & gi[0]) | (pi[1] & pi[0] & cin);
        cout[3] = gi[2] | (pi[2] & gi[1]) | (pi[2] & pi[1] & gi[0])
                | (pi[2] & pi[1] & pi[0] & cin);
        gg      = gi[3] | (pi[3] & gi[2]) | (pi[3] & pi[2] & gi[1])
                | (pi[3] & pi[2] & pi[1] & gi[0]);
        gp      = pi[3] & pi[2] & pi[1] & pi[0];
    end
endmodule

// File: rtl/hcla_bitpg.sv
// Module: per-bit generate and propagate.
// Propagate is the inclusive OR of the operand bits, not the XOR.
module hcla_bitpg #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] g,
    output logic [W-1:0] p
);
    // Purpose: form generate and propagate for every bit position.
    always_comb begin
        g = a & b;
        p = a | b;
    end
endmodule

// File: rtl/hcla_sumxor.sv
// Module: sum formation from the operand bits and the carry into each bit.
module hcla_sumxor #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s
);
    // Purpose: three-input XOR per bit.
    always_comb s = a ^ b ^ c;
endmodule

// File: rtl/hcla_adder64.sv
// Module: 64-bit adder with a three-level, fan-in-4 carry lookahead tree.
// Level 1: 16 units over bits give group terms and per-bit carries.
// Level 2: 4 units over groups give block terms and per-group carries.
// Level 3: 1 unit over blocks gives per-block carries and the carry-out.
// Assumes W = 64, so that 4 blocks exactly fill the top unit.
// Purely combinational, so it has no clock or reset.
module hcla_adder64 #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    import hcla_pkg::*;

    localparam int unsigned NGRP = W / LA_FANIN;
    localparam int unsigned NBLK = NGRP / LA_FANIN;

    logic [W-1:0]    bit_g, bit_p, bit_c;
    logic [NGRP-1:0] grp_g, grp_p, grp_c;
    logic [NBLK-1:0] blk_g, blk_p, blk_c;
    logic            top_g, top_p;
    logic [3:1]      top_c;

    hcla_bitpg #(.W(W)) u_pg (.a(a), .b(b), .g(bit_g), .p(bit_p));

    // Level 1: bit carries inside each group, and the group terms.
    for (genvar k = 0; k < NGRP; k++) begin : g_lvl1
        logic [3:1] cc;
        hcla_la4 u_la (
            .pi  (bit_p[LA_FANIN*k +: LA_FANIN]),
            .gi  (bit_g[LA_FANIN*k +: LA_FANIN]),
            .cin (grp_c[k]),
            .cout(cc),
            .gg  (grp_g[k]),
            .gp  (grp_p[k])
        );
        // Purpose: route the carry into each bit of group k.
        always_comb bit_c[LA_FANIN*k +: LA_FANIN] = {cc, grp_c[k]};
    end

    // Level 2: group carries inside each block, and the block terms.
    for (genvar m = 0; m < NBLK; m++) begin : g_lvl2
        logic [3:1] cc;
        hcla_la4 u_la (
            .pi  (grp_p[LA_FANIN*m +: LA_FANIN]),
            .gi  (grp_g[LA_FANIN*m +: LA_FANIN]),
            .cin (blk_c[m]),
            .cout(cc),
            .gg  (blk_g[m]),
            .gp  (blk_p[m])
        );
        // Purpose: route the carry into each group of block m.
        always_comb grp_c[LA_FANIN*m +: LA_FANIN] = {cc, blk_c[m]};
    end

    // Level 3: carries into the blocks from the adder carry-in.
    hcla_la4 u_top (
        .pi  (blk_p),
        .gi  (blk_g),
        .cin (ci),
        .cout(top_c),
        .gg  (top_g),
        .gp  (top_p)
    );

    // Purpose: block carries and the 64-bit carry-out.
    always_comb begin
        blk_c = {top_c, ci};
        co    = top_g | (top_p & ci);
    end

    hcla_sumxor #(.W(W)) u_sum (.a(a), .b(b), .c(bit_c), .s(s));
endmodule

// File: rtl/hcla_adder64_chk.sv
// Module: assertion checker for hcla_adder64, attached by bind.
// Compares the tree against plain addition and against the carry recurrence
// at bit, group and block level. Combinational, so immediate assertions only.
module hcla_adder64_chk #(
    parameter int unsigned W    = 64,
    parameter int unsigned NGRP = 16,
    parameter int unsigned NBLK = 4
) (
    input logic [W-1:0]    a,
    input logic [W-1:0]    b,
    input logic            ci,
    input logic [W-1:0]    s,
    input logic            co,
    input logic [W-1:0]    bit_g,
    input logic [W-1:0]    bit_p,
    input logic [W-1:0]    bit_c,
    input logic [NGRP-1:0] grp_g,
    input logic [NGRP-1:0] grp_p,
    input logic [NGRP-1:0] grp_c,
    input logic [NBLK-1:0] blk_g,
    input logic [NBLK-1:0] blk_p,
    input logic [NBLK-1:0] blk_c
);
    // Purpose: check the result and the recurrence at every tree level.
    always_comb begin
        a_r1_ref_sum: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
            else $error("R1 sum mismatch");
        for (int i = 0; i < W - 1; i++) begin
            a_r7_bit_carry: assert (bit_c[i+1] == (bit_g[i] | (bit_p[i] & bit_c[i])))
                else $error("R7 bit carry %0d", i + 1);
        end
        for (int k = 0; k < NGRP - 1; k++) begin
            a_r4_group_carry: assert (grp_c[k+1] == (grp_g[k] | (grp_p[k] & grp_c[k])))
                else $error("R4 group carry %0d", k + 1);
        end
        for (int m = 0; m < NBLK - 1; m++) begin
            a_r3_block_carry: assert (blk_c[m+1] == (blk_g[m] | (blk_p[m] & blk_c[m])))
                else $error("R3 block carry %0d", m + 1);
        end
        a_r3_carry_out: assert (co == (blk_g[NBLK-1] | (blk_p[NBLK-1] & blk_c[NBLK-1])))
            else $error("R3 carry out");
    end
endmodule

bind hcla_adder64 hcla_adder64_chk #(.W(W), .NGRP(NGRP), .NBLK(NBLK)) u_chk (
    .a(a), .b(b), .ci(ci), .s(s), .co(co),
    .bit_g(bit_g), .bit_p(bit_p), .bit_c(bit_c),
    .grp_g(grp_g), .grp_p(grp_p), .grp_c(grp_c),
    .blk_g(blk_g), .blk_p(blk_p), .blk_c(blk_c)
);

// File: tb/hcla_adder64_tb.sv
// Bench: directed scenarios for hcla_adder64, one task each, plus random operands.
module hcla_adder64_tb;
    localparam int unsigned W = 64;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    hcla_adder64 #(.W(W)) u_dut (.a(a), .b(b), .ci(ci), .s(s), .co(co));

    // Purpose: compare {co,s} with an expected 65-bit value.
    task automatic check(input string req, input logic [W:0] exp);
        n_checks++;
        if ({co, s} !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h ci=%b)",
                     req, {co, s}, exp, a, b, ci);
        end
    endtask

    // Purpose: drive away from the edge, let it settle, then check.
    task automatic apply(input string req, input logic [W-1:0] xa,
                         input logic [W-1:0] xb, input logic xc,
                         input logic [W:0] exp);
        @(negedge clk);
        a = xa; b = xb; ci = xc;
        #1;
        check(req, exp);
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] xa,
                                           input logic [W-1:0] xb, input logic xc);
        return {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
    endfunction

    task automatic t_r2_zero();
        apply("R2", '0, '0, 1'b0, '0);
        apply("R2", '0, '0, 1'b1, {{W{1'b0}}, 1'b1});
    endtask

    task automatic t_r3_full_propagate();
        apply("R3", '1, '0, 1'b1, {1'b1, {W{1'b0}}});
        apply("R3", '0, '1, 1'b1, {1'b1, {W{1'b0}}});
    endtask

    task automatic t_r4_group_generate();
        for (int k = 0; k < W / 4; k++) begin
            logic [W-1:0] xa, xb;
            logic [W:0]   e;
            xa = {{(W-4){1'b0}}, 4'hF} << (4 * k);
            xb = {{(W-1){1'b0}}, 1'b1} << (4 * k);
            e  = {{W{1'b0}}, 1'b1} << (4 * k + 4);
            apply("R4", xa, xb, 1'b0, e);
        end
    endtask

    task automatic t_r5_both_set();
        apply("R5", '1, '1, 1'b1, {1'b1, {W{1'b1}}});
        apply("R5", '1, '1, 1'b0, {1'b1, {(W-1){1'b1}}, 1'b0});
        apply("R5", {(W/8){8'h0F}}, {(W/8){8'h0F}}, 1'b0, {1'b0, {(W/8){8'h1E}}});
    endtask

    task automatic t_r6_alternating();
        apply("R6", {(W/4){4'h5}}, {(W/4){4'hA}}, 1'b0, {1'b0, {W{1'b1}}});
        apply("R6", {(W/4){4'h5}}, {(W/4){4'hA}}, 1'b1, {1'b1, {W{1'b0}}});
    endtask

    task automatic t_r7_single_bit();
        for (int i = 0; i < W; i++) begin
            logic [W-1:0] v;
            v = {{(W-1){1'b0}}, 1'b1} << i;
            apply("R7", v, v, 1'b0, {{W{1'b0}}, 1'b1} << (i + 1));
        end
    endtask

    task automatic t_r8_no_clock();
        @(posedge clk);
        #2;
        a = 64'h0000_0000_FFFF_FFFF; b = 64'h1; ci = 1'b0;
        #1;
        check("R8", 65'h0_0000_0001_0000_0000);
        a = 64'h8000_0000_0000_0000; b = 64'h8000_0000_0000_0000; ci = 1'b1;
        #1;
        check("R8", 65'h1_0000_0000_0000_0001);
    endtask

    task automatic t_r1_random();
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] xa, xb;
            logic         xc;
            xa = {$urandom(), $urandom()};
            xb = (n % 3 == 0) ? ~xa : {$urandom(), $urandom()};
            xc = 1'(n & 1);
            apply("R1", xa, xb, xc, ref_add(xa, xb, xc));
        end
    endtask

    // Purpose: watchdog, counts a hung run as a failure.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Purpose: run the scenarios in order.
    initial begin
        a = '0; b = '0; ci = 1'b0;
        t_r2_zero();
        t_r3_full_propagate();
        t_r4_group_generate();
        t_r5_both_set();
        t_r6_alternating();
        t_r7_single_bit();
        t_r8_no_clock();
        t_r1_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule